// File: doc/BRIEF.md
# Serial Receive Byte Buffer

This block sits between a serial deserializer and the register bank of a serial port. It stores received bytes until software reads them. A mode bit in its control register selects one of two storage paths. In FIFO mode, bytes pass through a circular queue of parameterised depth. In holding mode, a single register keeps only the newest byte.

The receiver side presents a byte with a one-cycle push strobe. A line-break condition uses its own strobe. Software takes a byte with a one-cycle pop strobe that stands for a read of the receive-data register. The popped byte appears on `pop_data` one cycle later.

The block exports several status outputs for the register decoder and the DMA engine:
- a fill status word,
- a data-ready flag,
- a clear-on-read error status,
- a sticky error-source flag,
- a DMA-busy line.

Writing to the control register can flush the receive storage. The same write can also send a one-cycle flush pulse to the transmit side. Neither flush bit is stored.

Top module: `rx_byte_buffer`

## Requirements
- R1: After synchronous reset the block is in holding mode, and all of the following read zero: `ctl_rdata`, `fill_status`, `data_ready`, `err_status`, `err_src`, `pop_data`, `tx_flush` and `dma_busy`.
- R2: In holding mode (`ctl_rdata[0]`=0), each push overwrites the single held byte and sets `data_ready`. A pop puts the held byte on `pop_data` in the next cycle and clears `data_ready`. Holding-mode traffic leaves the FIFO fill count unchanged.
- R3: In FIFO mode (`ctl_rdata[0]`=1), bytes are popped in the order they were pushed. This holds across read and write pointer wrap-around at `DEPTH` entries. `fill_status[7:0]` gives the number of stored entries.
- R4: In FIFO mode, a push into a full FIFO with no pop in the same cycle discards the byte, leaves the contents unchanged, and sets `err_src`.
- R5: In FIFO mode, a pop from an empty FIFO yields 0x00 on `pop_data`, sets `err_src` and leaves the count at zero.
- R6: `fill_status` bit 8 is the full flag. When the FIFO holds `DEPTH` entries, the word reads 0x100: the count field is 0 and only bit 8 is set.
- R7: A `push_break` strobe stores a 0x00 byte through the active path and sets `err_status[3]`. An `err_rd` strobe clears the whole `err_status` in the next cycle, unless a new break arrives in that same cycle.
- R8: In FIFO mode, `data_ready` is 1 exactly while at least one entry is stored. It stays 1 after a pop that leaves entries and drops to 0 after the pop that empties the FIFO.
- R9: A control write with `ctl_wdata[1]`=1 empties both storage paths at that edge. A write with `ctl_wdata[2]`=1 gives a one-cycle `tx_flush` pulse after the edge. `ctl_wdata[0]` is stored as the mode bit. Bits 2:1 of `ctl_rdata` always read 0.
- R10: `dma_busy` is 1 exactly when `rx_mode` equals 2'b10 and `data_ready` is 0.
- R11: In FIFO mode, a push and a pop in the same cycle leave the count unchanged and the pop returns the oldest byte. When the FIFO is full, that push is accepted without an error.
- R12: An `err_src_clr` strobe clears `err_src` in the next cycle, unless a new error is raised in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 3 | Control write data: bit 0 mode, bit 1 receive flush, bit 2 transmit flush |
| ctl_rdata | output | 3 | Control readback; flush bits always 0 |
| tx_flush | output | 1 | One-cycle flush pulse toward the transmit side |
| rx_mode | input | 2 | Receive mode field; 2'b10 selects DMA |
| push_valid | input | 1 | Received byte strobe |
| push_data | input | 8 | Received byte |
| push_break | input | 1 | Line-break strobe; stores 0x00, takes precedence over push_valid |
| pop_req | input | 1 | Receive-data register read strobe |
| pop_data | output | 8 | Byte taken by the last pop |
| fill_status | output | 9 | Count in bits 7:0, full flag in bit 8 |
| data_ready | output | 1 | A byte is waiting in the active path |
| err_status | output | 4 | Error status; bit 3 is break |
| err_rd | input | 1 | Error status read strobe (clears it) |
| err_src | output | 1 | Sticky error-interrupt source flag |
| err_src_clr | input | 1 | Clears err_src |
| dma_busy | output | 1 | DMA mode selected and no data waiting |

## Verification
A corrupted read pointer or stale queue entry shows up as a wrong byte on `pop_data` in the cycle after the pop. A scoreboard that follows push order catches it at the first bad pop, including after wrap-around. If the fill counter drifts away from the pointers, the count field, the full-flag encoding, `data_ready` and `dma_busy` all go wrong at once, one cycle after the push or pop that caused the drift. Lost or spurious error events show on `err_src` or `err_status[3]` one cycle after the overflow, empty pop or break.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

    localparam int BYTE_W      = 8;
    localparam int CTL_W       = 3;
    localparam int CTL_MODE    = 0;
    localparam int CTL_RX_CLR  = 1;
    localparam int CTL_TX_CLR  = 2;
    localparam int ERR_W       = 4;
    localparam int ERR_BREAK   = 3;
    localparam int STAT_W      = 9;
    localparam logic [1:0] MODE_RX_DMA = 2'b10;

    typedef enum logic {
        BUF_HOLD = 1'b0,
        BUF_FIFO = 1'b1
    } buf_mode_e;

    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } rx_beat_t;

    // Count field reads zero once the queue is full; only the full flag shows.
    function automatic logic [STAT_W-1:0] fill_word(input int unsigned count,
                                                    input int unsigned depth);
        logic [STAT_W-1:0] w;
        if (count == depth) begin
            w = {1'b1, {(STAT_W-1){1'b0}}};
        end else begin
            w = {1'b0, BYTE_W'(count)};
        end
        return w;
    endfunction

endpackage

// File: rtl/rxbuf_ctl.sv
module rxbuf_ctl
    import rxbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output buf_mode_e        mode,
    output logic             rx_flush,
    output logic             tx_flush,
    output logic [CTL_W-1:0] ctl_rdata
);

    buf_mode_e mode_q;
    logic      tx_flush_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q     <= BUF_HOLD;
            tx_flush_q <= 1'b0;
        end else begin
            tx_flush_q <= ctl_wr & ctl_wdata[CTL_TX_CLR];
            if (ctl_wr) begin
                mode_q <= buf_mode_e'(ctl_wdata[CTL_MODE]);
            end
        end
    end

    assign mode      = mode_q;
    assign rx_flush  = ctl_wr & ctl_wdata[CTL_RX_CLR];
    assign tx_flush  = tx_flush_q;
    assign ctl_rdata = {2'b00, mode_q};

    // R9: transmit flush request produces a pulse after the write edge
    a_r9_tx_pulse: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && ctl_wdata[CTL_TX_CLR]) |=> tx_flush);

    // R9: a pulse never appears without a write that asked for it
    a_r9_tx_cause: assert property (@(posedge clk) disable iff (rst)
        (!ctl_wr) |=> !tx_flush);

    // R9: mode bit follows the written value
    a_r9_mode_store: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (ctl_rdata[CTL_MODE] == $past(ctl_wdata[CTL_MODE])));

endmodule

// File: rtl/rxbuf_fifo.sv
module rxbuf_fifo
    import rxbuf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  rx_beat_t          wr_beat,
    input  logic              rd_req,
    output logic [BYTE_W-1:0] head,
    output logic              rd_ok,
    output logic              wr_drop,
    output logic              rd_empty_err,
    output logic [$clog2(DEPTH+1)-1:0] count
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr, rd_ptr;
    logic [CW-1:0]     cnt_q;
    logic              empty, full, wr_ok;

    function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
        return (p == LAST) ? '0 : p + PW'(1);
    endfunction

    assign empty        = (cnt_q == '0);
    assign full         = (cnt_q == FULL_CNT);
    assign rd_ok        = rd_req & ~empty;
    assign wr_ok        = wr_beat.valid & (~full | rd_ok);
    assign wr_drop      = wr_beat.valid & ~wr_ok;
    assign rd_empty_err = rd_req & empty;
    assign head         = mem[rd_ptr];
    assign count        = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            cnt_q  <= '0;
        end else begin
            if (wr_ok) begin
                wr_ptr <= next_ptr(wr_ptr);
            end
            if (rd_ok) begin
                rd_ptr <= next_ptr(rd_ptr);
            end
            cnt_q <= cnt_q + CW'(wr_ok) - CW'(rd_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (wr_ok && !flush) begin
            mem[wr_ptr] <= wr_beat.data;
        end
    end

    // R4: count never exceeds the storage depth
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= FULL_CNT);

    // R4: a rejected push leaves the fill level as it was
    a_r4_drop_keeps: assert property (@(posedge clk) disable iff (rst)
        (wr_drop && !rd_req && !flush) |=> $stable(cnt_q));

    // R11: simultaneous accepted push and pop keeps the count
    a_r11_count_hold: assert property (@(posedge clk) disable iff (rst)
        (wr_ok && rd_ok && !flush) |=> $stable(cnt_q));

    // R5: popping an empty queue without a push keeps it empty
    a_r5_stay_empty: assert property (@(posedge clk) disable iff (rst)
        (rd_empty_err && !wr_beat.valid) |=> (cnt_q == '0));

endmodule

// File: rtl/rxbuf_hold.sv
module rxbuf_hold
    import rxbuf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  rx_beat_t          load,
    input  logic              take,
    output logic [BYTE_W-1:0] held,
    output logic              valid
);

    logic [BYTE_W-1:0] held_q;
    logic              valid_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            held_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (load.valid) begin
                held_q <= load.data;
            end
            valid_q <= load.valid | (valid_q & ~take);
        end
    end

    assign held  = held_q;
    assign valid = valid_q;

    // R2: a read without a new byte empties the holding register
    a_r2_take_clears: assert property (@(posedge clk) disable iff (rst)
        (take && !load.valid) |=> !valid);

    // R2: a new byte is always marked ready
    a_r2_load_sets: assert property (@(posedge clk) disable iff (rst)
        (load.valid && !flush) |=> valid);

endmodule

// File: rtl/rxbuf_err.sv
module rxbuf_err
    import rxbuf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             brk_evt,
    input  logic             status_rd,
    input  logic             src_set,
    input  logic             src_clr,
    output logic [ERR_W-1:0] status,
    output logic             src
);

    logic brk_q;
    logic src_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_q <= 1'b0;
            src_q <= 1'b0;
        end else begin
            brk_q <= brk_evt | (brk_q & ~status_rd);
            src_q <= src_set | (src_q & ~src_clr);
        end
    end

    always_comb begin
        status            = '0;
        status[ERR_BREAK] = brk_q;
    end
    assign src = src_q;

    // R7: a break is recorded in the status word
    a_r7_break_flag: assert property (@(posedge clk) disable iff (rst)
        brk_evt |=> status[ERR_BREAK]);

    // R7: reading the status clears it completely
    a_r7_clear_on_read: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !brk_evt) |=> (status == '0));

    // R4 / R5: an error event raises the source flag
    a_r4_src_set: assert property (@(posedge clk) disable iff (rst)
        src_set |=> src);

    // R12: clearing without a new event drops the flag
    a_r12_src_clear: assert property (@(posedge clk) disable iff (rst)
        (src_clr && !src_set) |=> !src);

endmodule

// File: rtl/rx_byte_buffer.sv
module rx_byte_buffer
    import rxbuf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_rdata,
    output logic              tx_flush,
    input  logic [1:0]        rx_mode,
    input  logic              push_valid,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              push_break,
    input  logic              pop_req,
    output logic [BYTE_W-1:0] pop_data,
    output logic [STAT_W-1:0] fill_status,
    output logic              data_ready,
    output logic [ERR_W-1:0]  err_status,
    input  logic              err_rd,
    output logic              err_src,
    input  logic              err_src_clr,
    output logic              dma_busy
);

    localparam int CW = $clog2(DEPTH + 1);

    buf_mode_e         mode;
    logic              rx_flush;
    rx_beat_t          in_beat, fifo_beat, hold_beat;
    logic              fifo_pop, hold_take;
    logic [BYTE_W-1:0] fifo_head, hold_byte;
    logic              fifo_rd_ok, fifo_drop, fifo_empty_err;
    logic [CW-1:0]     fifo_count;
    logic              hold_valid;
    logic [BYTE_W-1:0] pop_q;

    // Break takes precedence over an ordinary byte and always carries 0x00.
    always_comb begin
        in_beat.valid = push_valid | push_break;
        in_beat.data  = push_break ? '0 : push_data;
    end

    always_comb begin
        fifo_beat       = in_beat;
        fifo_beat.valid = in_beat.valid & (mode == BUF_FIFO) & ~rx_flush;
        hold_beat       = in_beat;
        hold_beat.valid = in_beat.valid & (mode == BUF_HOLD) & ~rx_flush;
    end

    assign fifo_pop  = pop_req & (mode == BUF_FIFO) & ~rx_flush;
    assign hold_take = pop_req & (mode == BUF_HOLD) & ~rx_flush;

    rxbuf_ctl i_ctl (
        .clk       (clk),
        .rst       (rst),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .mode      (mode),
        .rx_flush  (rx_flush),
        .tx_flush  (tx_flush),
        .ctl_rdata (ctl_rdata)
    );

    rxbuf_fifo #(.DEPTH(DEPTH)) i_fifo (
        .clk          (clk),
        .rst          (rst),
        .flush        (rx_flush),
        .wr_beat      (fifo_beat),
        .rd_req       (fifo_pop),
        .head         (fifo_head),
        .rd_ok        (fifo_rd_ok),
        .wr_drop      (fifo_drop),
        .rd_empty_err (fifo_empty_err),
        .count        (fifo_count)
    );

    rxbuf_hold i_hold (
        .clk   (clk),
        .rst   (rst),
        .flush (rx_flush),
        .load  (hold_beat),
        .take  (hold_take),
        .held  (hold_byte),
        .valid (hold_valid)
    );

    rxbuf_err i_err (
        .clk       (clk),
        .rst       (rst),
        .brk_evt   (push_break),
        .status_rd (err_rd),
        .src_set   (fifo_drop | fifo_empty_err),
        .src_clr   (err_src_clr),
        .status    (err_status),
        .src       (err_src)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pop_q <= '0;
        end else if (fifo_pop) begin
            pop_q <= fifo_rd_ok ? fifo_head : '0;
        end else if (hold_take) begin
            pop_q <= hold_byte;
        end
    end

    assign pop_data    = pop_q;
    assign fill_status = fill_word(int'(fifo_count), DEPTH);
    assign data_ready  = (mode == BUF_FIFO) ? (fifo_count != '0) : hold_valid;
    assign dma_busy    = (rx_mode == MODE_RX_DMA) & ~data_ready;

    // R8: an accepted byte with no pop and no control write leaves data waiting
    a_r8_ready_after_push: assert property (@(posedge clk) disable iff (rst)
        (in_beat.valid && !pop_req && !ctl_wr) |=> data_ready);

    // R5: an empty-queue pop delivers a zero byte
    a_r5_zero_on_empty: assert property (@(posedge clk) disable iff (rst)
        fifo_empty_err |=> (pop_data == '0));

    // R9: a receive flush leaves nothing waiting
    a_r9_rx_flush: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> (!data_ready && fill_status == '0));

endmodule

// File: tb/test_rx_byte_buffer.sv
module test_rx_byte_buffer;
    import rxbuf_pkg::*;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_wr = 1'b0;
    logic [2:0] ctl_wdata = '0;
    logic [2:0] ctl_rdata;
    logic       tx_flush;
    logic [1:0] rx_mode = 2'b00;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       push_break = 1'b0;
    logic       pop_req = 1'b0;
    logic [7:0] pop_data;
    logic [8:0] fill_status;
    logic       data_ready;
    logic [3:0] err_status;
    logic       err_rd = 1'b0;
    logic       err_src;
    logic       err_src_clr = 1'b0;
    logic       dma_busy;

    always #4 clk = ~clk;

    rx_byte_buffer #(.DEPTH(DEPTH)) i_rx_byte_buffer (
        .clk         (clk),
        .rst         (rst),
        .ctl_wr      (ctl_wr),
        .ctl_wdata   (ctl_wdata),
        .ctl_rdata   (ctl_rdata),
        .tx_flush    (tx_flush),
        .rx_mode     (rx_mode),
        .push_valid  (push_valid),
        .push_data   (push_data),
        .push_break  (push_break),
        .pop_req     (pop_req),
        .pop_data    (pop_data),
        .fill_status (fill_status),
        .data_ready  (data_ready),
        .err_status  (err_status),
        .err_rd      (err_rd),
        .err_src     (err_src),
        .err_src_clr (err_src_clr),
        .dma_busy    (dma_busy)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // Reference model state
    logic [7:0] model_q[$];
    logic [7:0] hold_b = '0;
    bit         fifo_on = 1'b0;

    // Scoreboard of expected popped bytes
    logic [7:0] exp_q[$];
    string      tag_q[$];

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    // Monitor: compares each popped byte against the scoreboard
    always @(posedge clk) begin
        if (pop_req && !rst) begin
            #2;
            if (exp_q.size() == 0) begin
                chk("scoreboard underrun", 1, 0);
            end else begin
                chk(tag_q.pop_front(), int'(pop_data), int'(exp_q.pop_front()));
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic model_push(input logic [7:0] b);
        if (fifo_on) begin
            if (model_q.size() < DEPTH) model_q.push_back(b);
        end else begin
            hold_b = b;
        end
    endtask

    function automatic logic [7:0] model_pop();
        logic [7:0] e;
        if (fifo_on) begin
            e = (model_q.size() != 0) ? model_q.pop_front() : 8'h00;
        end else begin
            e = hold_b;
        end
        return e;
    endfunction

    task automatic push(input logic [7:0] b);
        push_valid = 1'b1;
        push_data  = b;
        tick();
        push_valid = 1'b0;
        model_push(b);
    endtask

    task automatic push_brk();
        push_break = 1'b1;
        tick();
        push_break = 1'b0;
        model_push(8'h00);
    endtask

    task automatic pop(input string tag);
        exp_q.push_back(model_pop());
        tag_q.push_back(tag);
        pop_req = 1'b1;
        tick();
        pop_req = 1'b0;
    endtask

    task automatic push_pop(input logic [7:0] b, input string tag);
        exp_q.push_back(model_pop());
        tag_q.push_back(tag);
        model_push(b);
        push_valid = 1'b1;
        push_data  = b;
        pop_req    = 1'b1;
        tick();
        push_valid = 1'b0;
        pop_req    = 1'b0;
    endtask

    task automatic ctl_write(input logic [2:0] w);
        ctl_wr    = 1'b1;
        ctl_wdata = w;
        tick();
        ctl_wr = 1'b0;
        if (w[1]) begin
            model_q.delete();
        end
        fifo_on = w[0];
    endtask

    task automatic pulse_src_clr();
        err_src_clr = 1'b1;
        tick();
        err_src_clr = 1'b0;
    endtask

    function automatic int exp_fill();
        return (model_q.size() == DEPTH) ? 'h100 : model_q.size();
    endfunction

    initial begin
        #(8 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R1: reset state
        chk("R1 ctl_rdata", int'(ctl_rdata), 0);
        chk("R1 fill_status", int'(fill_status), 0);
        chk("R1 data_ready", int'(data_ready), 0);
        chk("R1 err_status", int'(err_status), 0);
        chk("R1 err_src", int'(err_src), 0);
        chk("R1 pop_data", int'(pop_data), 0);
        chk("R1 tx_flush", int'(tx_flush), 0);
        chk("R1 dma_busy", int'(dma_busy), 0);

        // R10: DMA mode with nothing waiting
        rx_mode = 2'b10;
        #1;
        chk("R10 dma_busy idle", int'(dma_busy), 1);

        // R2: holding mode
        push(8'h41);
        chk("R2 ready after push", int'(data_ready), 1);
        chk("R10 dma_busy with data", int'(dma_busy), 0);
        push(8'h42);
        pop("R2 overwrite pop");
        chk("R2 ready after pop", int'(data_ready), 0);
        chk("R2 fill untouched", int'(fill_status), 0);
        chk("R10 dma_busy after pop", int'(dma_busy), 1);
        rx_mode = 2'b01;
        #1;
        chk("R10 dma_busy non-dma mode", int'(dma_busy), 0);
        rx_mode = 2'b00;

        // R9: enter FIFO mode
        ctl_write(3'b001);
        chk("R9 mode readback", int'(ctl_rdata), 1);

        // R3 / R6: fill the queue
        for (int i = 0; i < DEPTH; i++) begin
            push(8'(8'h10 + i));
            if (i == 2) chk("R3 count field", int'(fill_status), 3);
        end
        chk("R6 full word", int'(fill_status), exp_fill());
        chk("R6 full word literal", int'(fill_status), 'h100);
        chk("R8 ready when full", int'(data_ready), 1);

        // R4: overflow
        push(8'hEE);
        chk("R4 err_src on overflow", int'(err_src), 1);
        chk("R4 fill after overflow", int'(fill_status), 'h100);

        // R12: clear the source flag
        pulse_src_clr();
        chk("R12 err_src cleared", int'(err_src), 0);

        // R11: push and pop while full
        push_pop(8'h77, "R11 oldest byte on full push_pop");
        chk("R11 fill unchanged", int'(fill_status), 'h100);
        chk("R11 no error on full push_pop", int'(err_src), 0);

        // R3 / R8: drain across the wrap point
        for (int i = 1; i < DEPTH; i++) begin
            pop("R3 drain order");
        end
        chk("R8 ready with one left", int'(data_ready), 1);
        chk("R3 count one left", int'(fill_status), 1);
        pop("R3 wrapped byte");
        chk("R8 ready after last pop", int'(data_ready), 0);
        chk("R3 count empty", int'(fill_status), 0);

        // R5: empty pop
        pop("R5 zero on empty pop");
        chk("R5 err_src on empty pop", int'(err_src), 1);
        chk("R5 count stays zero", int'(fill_status), 0);
        pulse_src_clr();

        // R7: break
        push_brk();
        chk("R7 break stored", int'(fill_status), 1);
        chk("R7 break status", int'(err_status), 8);
        pop("R7 break byte is zero");
        chk("R7 status kept after pop", int'(err_status), 8);
        err_rd = 1'b1;
        tick();
        err_rd = 1'b0;
        chk("R7 status cleared on read", int'(err_status), 0);

        // R9: flush with both reset bits
        push(8'hA1);
        push(8'hA2);
        push(8'hA3);
        ctl_write(3'b111);
        chk("R9 tx_flush pulse", int'(tx_flush), 1);
        chk("R9 fill after flush", int'(fill_status), 0);
        chk("R9 ready after flush", int'(data_ready), 0);
        chk("R9 reset bits read zero", int'(ctl_rdata), 1);
        tick();
        chk("R9 tx_flush single cycle", int'(tx_flush), 0);

        // R11: push and pop with entries stored
        push(8'hB1);
        push(8'hB2);
        push_pop(8'hB3, "R11 oldest byte");
        chk("R11 count kept", int'(fill_status), 2);
        pop("R3 after push_pop 1");
        pop("R3 after push_pop 2");
        chk("R8 empty at end", int'(data_ready), 0);

        tick();
        tick();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule